// File: doc/BRIEF.md
# Two-Cycle Command Sequence Generator

This block sits between a memory controller's scheduler and the command/address pins of a low-power DRAM channel. The scheduler hands it one high-level request at a time through a ready/valid handshake: open a row, read, write, masked write, close a bank or all banks, refresh, read a mode register or write a mode register. Each request carries a bank, row and column, plus burst-length, auto-precharge, all-banks, mode-register-address and mode-register-data fields. The block turns the request into one or two bus commands on a 6-bit single-data-rate command bus with an active-high chip select. Every command occupies two clocks: chip select is high in the first and low in the second.

Row opens, reads, writes, masked writes and mode register reads are built from two commands, so they take four bus clocks. Read-type and write-type requests are completed by a column-address command. Mode register writes are split into two halves. Bank close and refresh are single commands of two clocks. Before any request is accepted, its column is checked against the alignment rule for its operation. A misaligned request is consumed, reported by a one-cycle error pulse, and produces nothing on the bus. DRAM timing spacing, the data bus and training are left to the surrounding controller.

The sequencer has five states. ST_IDLE waits and drives NOP. ST_FIRST_HI and ST_FIRST_LO are the two clocks of the first command. ST_SECOND_HI and ST_SECOND_LO are the two clocks of the second command. The transitions are:
- ST_IDLE to ST_FIRST_HI on a valid, aligned request.
- ST_FIRST_HI to ST_FIRST_LO always.
- ST_FIRST_LO to ST_SECOND_HI for two-command requests, and to ST_IDLE otherwise.
- ST_SECOND_HI to ST_SECOND_LO always.
- ST_SECOND_LO to ST_IDLE always.

Top module: `cmd_seq_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `cs` is 0, `ca` is 0 and `req_err` is 0.
- R2: While no command is in progress, the bus carries NOP: `cs`=0 and `ca`=000000.
- R3: Every command occupies exactly two consecutive clocks, with `cs`=1 in the first and `cs`=0 in the second. The first bus clock follows the accepting edge directly.
- R4: Request code 0 (row open) emits two commands. The first is Activate-1: ca[0]=1, ca[1]=0, ca[5:2]=row[15:12]; then ca[2:0]=bank, ca[3]=row[16], ca[4]=row[10], ca[5]=row[11]. The second is Activate-2: ca[1:0]=11, ca[5:2]=row[9:6]; then ca[5:0]=row[5:0].
- R5: Request code 1 (read) emits Read-1: ca[1]=1, ca[5]=burst select, other bits 0. Its second clock has ca[2:0]=bank, ca[3]=0, ca[4]=col[9], ca[5]=auto-precharge. A column-address command follows.
- R6: Request code 2 (write) emits Write-1 with ca[2]=1 and ca[5]=burst select. Request code 3 (masked write) emits ca[3:2]=11 with ca[5]=0. Each has the same second clock as a read and is followed by a column-address command.
- R7: The column-address command has ca[1]=1, ca[4]=1 and ca[5]=col[8] in its first clock, and ca[5:0]=col[7:2] in its second.
- R8: Request code 4 (bank close) emits ca[4]=1 with ca[5]=all-banks flag. Request code 5 (refresh) emits ca[3]=1 with ca[5]=all-banks flag. Each has ca[2:0]=bank in its second clock and is a single command.
- R9: Request code 6 (mode register read) emits ca[3:1]=111, then ca=register address, followed by a column-address command whose column bits are all 0 whatever `req_col` holds. Request code 7 (mode register write) emits ca[2:1]=11 with ca[5]=data[7], then ca=address. It then emits ca[4]=1, ca[2:1]=11 with ca[5]=data[6], then ca=data[5:0].
- R10: A read whose col[1:0] is not 0, or a write or masked write whose col[3:0] is not 0, is consumed without any bus activity. `req_err` is 1 for exactly the cycle after the accepting edge, and `req_ready` stays 1.
- R11: `req_ready` is 0 in every clock of a command sequence and 1 otherwise. A request is taken only on an edge where `req_valid` and `req_ready` are both 1. Back-to-back requests are separated by exactly one NOP clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Request code (0 open, 1 read, 2 write, 3 masked write, 4 close, 5 refresh, 6 mode read, 7 mode write) |
| req_bank | input | 3 | Bank address |
| req_row | input | 17 | Row address |
| req_col | input | 10 | Column address |
| req_bl | input | 1 | Burst-length select for read and write |
| req_ap | input | 1 | Auto-precharge flag |
| req_all | input | 1 | All-banks flag for close and refresh |
| req_mra | input | 6 | Mode register address |
| req_mrd | input | 8 | Mode register write data |
| req_err | output | 1 | One-cycle pulse: last request rejected for misalignment |
| cs | output | 1 | Chip select, high in the first clock of each command |
| ca | output | 6 | Command/address bus |

## Verification
Each request code is driven with row, bank and column values that place distinct ones and zeros in every field. A wrong bit slice or a swapped field therefore shows up as a wrong bus word. Burst-select, auto-precharge and all-banks are each tried at both values, which separates a dropped flag from a stuck one. Columns that are aligned for reads but not for writes, and columns with only bit 3 set, distinguish the two alignment rules. A mode register read with a non-zero column shows whether the column is forced to zero. Requests issued back to back, with valid held high across the sequence, show that nothing is taken while busy and that the idle gap is exactly one clock.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    parameter int CA_W      = 6;
    parameter int BANK_W    = 3;
    parameter int ROW_W     = 17;
    parameter int COL_W     = 10;
    parameter int MRA_W     = 6;
    parameter int MRD_W     = 8;
    parameter int RD_ALIGN  = 2;   // low column bits that must be zero on a read
    parameter int WR_ALIGN  = 4;   // low column bits that must be zero on a write

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_MWR = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_MRR = 3'd6,
        OP_MRW = 3'd7
    } req_op_e;

    typedef enum logic [3:0] {
        SC_NONE,
        SC_ACT1,
        SC_ACT2,
        SC_RD1,
        SC_WR1,
        SC_MWR1,
        SC_CAS2,
        SC_PRE,
        SC_REF,
        SC_MRR1,
        SC_MRW1,
        SC_MRW2
    } subcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST_HI,
        ST_FIRST_LO,
        ST_SECOND_HI,
        ST_SECOND_LO
    } seq_state_e;

    typedef struct packed {
        req_op_e            op;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic               bl;
        logic               ap;
        logic               all;
        logic [MRA_W-1:0]   mra;
        logic [MRD_W-1:0]   mrd;
    } req_t;

endpackage

// File: rtl/cmd_seq_align.sv
module cmd_seq_align
    import cmdseq_pkg::*;
(
    input  req_op_e          op,
    input  logic [COL_W-1:0] col,
    output logic             aligned
);

    localparam int RD_MASK_W = RD_ALIGN;
    localparam int WR_MASK_W = WR_ALIGN;

    always_comb begin
        unique case (op)
            OP_RD:          aligned = (col[RD_MASK_W-1:0] == '0);
            OP_WR, OP_MWR:  aligned = (col[WR_MASK_W-1:0] == '0);
            default:        aligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmdseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        aligned,
    input  logic        two_cmds,
    output logic        ready,
    output logic        load,
    output logic        err,
    output seq_state_e  state
);

    seq_state_e state_n;
    logic       two_q;
    logic       err_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            two_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            state <= state_n;
            err_q <= ready && valid && !aligned;
            if (load) begin
                two_q <= two_cmds;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (valid && aligned) state_n = ST_FIRST_HI;
            ST_FIRST_HI:  state_n = ST_FIRST_LO;
            ST_FIRST_LO:  state_n = two_q ? ST_SECOND_HI : ST_IDLE;
            ST_SECOND_HI: state_n = ST_SECOND_LO;
            ST_SECOND_LO: state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready = (state == ST_IDLE);
        load  = ready && valid && aligned;
        err   = err_q;
    end

endmodule

// File: rtl/cmd_seq_encoder.sv
module cmd_seq_encoder
    import cmdseq_pkg::*;
(
    input  subcmd_e  sc,
    input  logic     hi_phase,
    input  req_t     rq,
    output logic [CA_W-1:0] ca
);

    logic [CA_W-1:0] bank_word;

    always_comb begin
        bank_word      = '0;
        bank_word[2:0] = rq.bank;
    end

    always_comb begin
        ca = '0;
        unique case (sc)
            SC_NONE: ca = '0;
            SC_ACT1: begin
                if (hi_phase) ca = {rq.row[15:12], 1'b0, 1'b1};
                else          ca = {rq.row[11], rq.row[10], rq.row[16], rq.bank};
            end
            SC_ACT2: begin
                if (hi_phase) ca = {rq.row[9:6], 2'b11};
                else          ca = rq.row[5:0];
            end
            SC_RD1: begin
                if (hi_phase) ca = {rq.bl, 5'b00010};
                else          ca = {rq.ap, rq.col[9], 1'b0, rq.bank};
            end
            SC_WR1: begin
                if (hi_phase) ca = {rq.bl, 5'b00100};
                else          ca = {rq.ap, rq.col[9], 1'b0, rq.bank};
            end
            SC_MWR1: begin
                if (hi_phase) ca = 6'b001100;
                else          ca = {rq.ap, rq.col[9], 1'b0, rq.bank};
            end
            SC_CAS2: begin
                if (hi_phase) ca = {rq.col[8], 5'b10010};
                else          ca = rq.col[7:2];
            end
            SC_PRE: begin
                if (hi_phase) ca = {rq.all, 5'b10000};
                else          ca = bank_word;
            end
            SC_REF: begin
                if (hi_phase) ca = {rq.all, 5'b01000};
                else          ca = bank_word;
            end
            SC_MRR1: begin
                if (hi_phase) ca = 6'b001110;
                else          ca = rq.mra;
            end
            SC_MRW1: begin
                if (hi_phase) ca = {rq.mrd[7], 5'b00110};
                else          ca = rq.mra;
            end
            SC_MRW2: begin
                if (hi_phase) ca = {rq.mrd[6], 5'b10110};
                else          ca = rq.mrd[5:0];
            end
            default: ca = '0;
        endcase
    end

endmodule

// File: rtl/cmd_seq_gen.sv
module cmd_seq_gen
    import cmdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_bl,
    input  logic              req_ap,
    input  logic              req_all,
    input  logic [MRA_W-1:0]  req_mra,
    input  logic [MRD_W-1:0]  req_mrd,
    output logic              req_err,
    output logic              cs,
    output logic [CA_W-1:0]   ca
);

    req_op_e    op_in;
    logic       aligned;
    logic       two_cmds;
    logic       load;
    seq_state_e state;
    req_t       rq_q;
    subcmd_e    sc_first;
    subcmd_e    sc_second;
    subcmd_e    sc_cur;
    logic       hi_phase;

    assign op_in = req_op_e'(req_op);

    // requests that carry an address need a second command
    always_comb begin
        unique case (op_in)
            OP_PRE, OP_REF: two_cmds = 1'b0;
            default:        two_cmds = 1'b1;
        endcase
    end

    cmd_seq_align u_align (
        .op      (op_in),
        .col     (req_col),
        .aligned (aligned)
    );

    cmd_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (req_valid),
        .aligned  (aligned),
        .two_cmds (two_cmds),
        .ready    (req_ready),
        .load     (load),
        .err      (req_err),
        .state    (state)
    );

    // request capture; a mode register read always sends a zero column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else if (load) begin
            rq_q.op   <= op_in;
            rq_q.bank <= req_bank;
            rq_q.row  <= req_row;
            rq_q.col  <= (op_in == OP_MRR) ? '0 : req_col;
            rq_q.bl   <= req_bl;
            rq_q.ap   <= req_ap;
            rq_q.all  <= req_all;
            rq_q.mra  <= req_mra;
            rq_q.mrd  <= req_mrd;
        end
    end

    always_comb begin
        unique case (rq_q.op)
            OP_ACT: begin sc_first = SC_ACT1; sc_second = SC_ACT2; end
            OP_RD:  begin sc_first = SC_RD1;  sc_second = SC_CAS2; end
            OP_WR:  begin sc_first = SC_WR1;  sc_second = SC_CAS2; end
            OP_MWR: begin sc_first = SC_MWR1; sc_second = SC_CAS2; end
            OP_PRE: begin sc_first = SC_PRE;  sc_second = SC_NONE; end
            OP_REF: begin sc_first = SC_REF;  sc_second = SC_NONE; end
            OP_MRR: begin sc_first = SC_MRR1; sc_second = SC_CAS2; end
            OP_MRW: begin sc_first = SC_MRW1; sc_second = SC_MRW2; end
            default: begin sc_first = SC_NONE; sc_second = SC_NONE; end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FIRST_HI:  begin sc_cur = sc_first;  hi_phase = 1'b1; end
            ST_FIRST_LO:  begin sc_cur = sc_first;  hi_phase = 1'b0; end
            ST_SECOND_HI: begin sc_cur = sc_second; hi_phase = 1'b1; end
            ST_SECOND_LO: begin sc_cur = sc_second; hi_phase = 1'b0; end
            default:      begin sc_cur = SC_NONE;   hi_phase = 1'b0; end
        endcase
    end

    cmd_seq_encoder u_enc (
        .sc       (sc_cur),
        .hi_phase (hi_phase),
        .rq       (rq_q),
        .ca       (ca)
    );

    assign cs = hi_phase;

endmodule

// File: rtl/cmd_seq_gen_chk.sv
module cmd_seq_gen_chk
    import cmdseq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            req_err,
    input logic            cs,
    input logic [CA_W-1:0] ca
);

    p_cs_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> !cs);

    p_second_half_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> !req_ready);

    p_busy_when_selected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> !req_ready);

    p_idle_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cs && ca == '0));

    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && !cs));

endmodule

bind cmd_seq_gen cmd_seq_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .cs        (cs),
    .ca        (ca)
);

// File: tb/tb_cmd_seq_gen.sv
module tb_cmd_seq_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [2:0]  req_bank = '0;
    logic [16:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_bl = 1'b0;
    logic        req_ap = 1'b0;
    logic        req_all = 1'b0;
    logic [5:0]  req_mra = '0;
    logic [7:0]  req_mrd = '0;
    logic        req_err;
    logic        cs;
    logic [5:0]  ca;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R2";
    logic [6:0] expq[$];
    bit err_pend = 0;
    bit mon_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    cmd_seq_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_bl(req_bl), .req_ap(req_ap), .req_all(req_all), .req_mra(req_mra),
        .req_mrd(req_mrd), .req_err(req_err), .cs(cs), .ca(ca)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model: queue the bus words a request should produce
    task automatic model_push(logic [2:0] op, logic [2:0] bank, logic [16:0] row,
                              logic [9:0] col, logic bl, logic ap, logic all,
                              logic [5:0] mra, logic [7:0] mrd);
        logic [5:0] cas_hi;
        logic [5:0] cas_lo;
        logic [5:0] rw_lo;
        cas_hi = {col[8], 5'b10010};
        cas_lo = col[7:2];
        rw_lo  = {ap, col[9], 1'b0, bank};
        case (op)
            3'd0: begin
                expq.push_back({1'b1, row[15:12], 2'b01});
                expq.push_back({1'b0, row[11], row[10], row[16], bank});
                expq.push_back({1'b1, row[9:6], 2'b11});
                expq.push_back({1'b0, row[5:0]});
            end
            3'd1, 3'd2, 3'd3: begin
                if ((op == 3'd1 && col[1:0] != 0) || (op != 3'd1 && col[3:0] != 0)) begin
                    err_pend = 1;
                end else begin
                    if (op == 3'd1)      expq.push_back({1'b1, bl, 5'b00010});
                    else if (op == 3'd2) expq.push_back({1'b1, bl, 5'b00100});
                    else                 expq.push_back({1'b1, 6'b001100});
                    expq.push_back({1'b0, rw_lo});
                    expq.push_back({1'b1, cas_hi});
                    expq.push_back({1'b0, cas_lo});
                end
            end
            3'd4, 3'd5: begin
                expq.push_back({1'b1, all, (op == 3'd4) ? 5'b10000 : 5'b01000});
                expq.push_back({1'b0, 3'b000, bank});
            end
            3'd6: begin
                expq.push_back({1'b1, 6'b001110});
                expq.push_back({1'b0, mra});
                expq.push_back({1'b1, 6'b010010});
                expq.push_back({1'b0, 6'b000000});
            end
            default: begin
                expq.push_back({1'b1, mrd[7], 5'b00110});
                expq.push_back({1'b0, mra});
                expq.push_back({1'b1, mrd[6], 5'b10110});
                expq.push_back({1'b0, mrd[5:0]});
            end
        endcase
    endtask

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            logic [6:0] exp_w;
            bit exp_rdy;
            exp_rdy = (expq.size() == 0);
            exp_w = exp_rdy ? 7'b0 : expq[0];
            check(exp_rdy ? "R2" : tag, {9'b0, cs, ca}, {9'b0, exp_w}, "cs/ca");   // R2 R3
            check("R11", {15'b0, req_ready}, {15'b0, exp_rdy}, "ready");
            check("R10", {15'b0, req_err}, {15'b0, err_pend}, "err");
            err_pend = 0;
            if (!exp_rdy) void'(expq.pop_front());
            if (req_valid && exp_rdy) begin
                model_push(req_op, req_bank, req_row, req_col, req_bl, req_ap,
                           req_all, req_mra, req_mrd);
            end
        end
    end

    // called just after a rising edge; returns just after the accepting edge
    task automatic send(string t, logic [2:0] op, logic [2:0] bank, logic [16:0] row,
                        logic [9:0] col, logic bl, logic ap, logic all,
                        logic [5:0] mra, logic [7:0] mrd);
        bit acc;
        tag = t;
        req_valid = 1'b1; req_op = op; req_bank = bank; req_row = row; req_col = col;
        req_bl = bl; req_ap = ap; req_all = all; req_mra = mra; req_mrd = mrd;
        do begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
        end while (!acc);
        #1 req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        repeat (2) @(negedge clk);
        check("R1", {15'b0, req_ready}, 16'd1, "ready in reset");
        check("R1", {9'b0, cs, ca}, 16'd0, "bus in reset");
        check("R1", {15'b0, req_err}, 16'd0, "err in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        mon_on = 1;
        idle(3);                                                   // R2 idle NOP

        // R4: row open, fields with mixed bits
        send("R4", 3'd0, 3'd5, 17'h1_A5C3, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        idle(5);
        send("R4", 3'd0, 3'd2, 17'h0_5A3C, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        idle(5);
        // R5 R7: read, both burst and auto-precharge values, aligned to 4
        send("R5", 3'd1, 3'd3, 17'd0, 10'h2AC, 1, 0, 0, 6'd0, 8'd0);
        idle(5);
        send("R7", 3'd1, 3'd4, 17'd0, 10'h154, 0, 1, 0, 6'd0, 8'd0);
        idle(5);
        // R6: write and masked write
        send("R6", 3'd2, 3'd6, 17'd0, 10'h3F0, 1, 1, 0, 6'd0, 8'd0);
        idle(5);
        send("R6", 3'd3, 3'd1, 17'd0, 10'h150, 1, 0, 0, 6'd0, 8'd0);
        idle(5);
        // R8: close single/all, refresh
        send("R8", 3'd4, 3'd7, 17'd0, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        idle(3);
        send("R8", 3'd4, 3'd2, 17'd0, 10'd0, 0, 0, 1, 6'd0, 8'd0);
        idle(3);
        send("R8", 3'd5, 3'd5, 17'd0, 10'd0, 0, 0, 1, 6'd0, 8'd0);
        idle(3);
        // R9: mode register read with nonzero column, mode register write
        send("R9", 3'd6, 3'd0, 17'd0, 10'h3FF, 0, 0, 0, 6'h2D, 8'd0);
        idle(5);
        send("R9", 3'd7, 3'd0, 17'd0, 10'd0, 0, 0, 0, 6'h13, 8'hB6);
        idle(5);
        send("R9", 3'd7, 3'd0, 17'd0, 10'd0, 0, 0, 0, 6'h2C, 8'h49);
        idle(5);
        // R10: misaligned columns rejected, aligned edge cases accepted
        send("R10", 3'd1, 3'd1, 17'd0, 10'h002, 0, 0, 0, 6'd0, 8'd0);
        idle(3);
        send("R10", 3'd2, 3'd1, 17'd0, 10'h004, 0, 0, 0, 6'd0, 8'd0);
        idle(3);
        send("R10", 3'd3, 3'd1, 17'd0, 10'h008, 0, 0, 0, 6'd0, 8'd0);
        idle(3);
        send("R10", 3'd1, 3'd1, 17'd0, 10'h00C, 0, 0, 0, 6'd0, 8'd0);
        idle(5);
        // R11: back-to-back requests with valid held, then reject then accept
        send("R11", 3'd0, 3'd3, 17'h0_FFFF, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        send("R11", 3'd1, 3'd3, 17'd0, 10'h3FC, 1, 1, 0, 6'd0, 8'd0);
        send("R11", 3'd5, 3'd0, 17'd0, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        send("R11", 3'd2, 3'd0, 17'd0, 10'h001, 0, 0, 0, 6'd0, 8'd0);
        send("R11", 3'd4, 3'd6, 17'd0, 10'd0, 0, 0, 0, 6'd0, 8'd0);
        idle(6);
        mon_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule